// File: doc/BRIEF.md
# Fractional-Ratio 50% Duty Output Divider

This block takes a fast input clock and produces a slower clock whose ratio to the input is picked from eight values by a 3-bit code: 1, 1.5, 2, 3, 4, 6, 8 or 12. For every integer ratio the output stays high for as long as it stays low. The half-integer ratio 1.5 cannot be split evenly, so its high and low times differ by exactly one input half-period. Each output changes on either edge of the input clock. A state machine clocked on the rising edge and a second one clocked on the falling edge build it together.

The same divided waveform drives several identical output channels. A one-cycle strobe, synchronous to the rising input edge, marks every input cycle that contains an output rising edge. A simulation or a downstream synchronous check can use it without sampling the divided clock. A new code is taken up only when the current repeating pattern ends, so an output period is always complete. A synchronous active-high reset drives the outputs low. When reset is released, a fresh output period starts at once.

Top module: `frac_clk_div`

## Requirements
- R1: The code on `sel_i` sets the output period, counted in input half-periods: 000→2, 001→3, 010→4, 011→6, 100→8, 101→12, 110→16, 111→24.
- R2: For codes 000 and 010 to 111, the output high time equals the low time. For code 001 the output is high for two input half-periods and low for one.
- R3: All bits of `clk_o` carry the same waveform at all times outside reset.
- R4: A code change on `sel_i` is taken up only when the current repeating pattern ends. For code 001 the pattern is two output periods; for any other code it is one. Every output period is therefore either a whole period of the old ratio or a whole period of the new ratio.
- R5: While `rst_i` is sampled high on rising input edges, `tick_o` is low after the first such edge. Every bit of `clk_o` is low from the next falling input edge onward.
- R6: On the first rising input edge that samples `rst_i` low after reset, an output period starts. `clk_o` rises at that edge and `tick_o` goes high, and the period follows the code on `sel_i` at that edge.
- R7: `tick_o` is high for exactly those input cycles, from one rising input edge to the next, in which an output rising edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock; both of its edges are used |
| rst_i | input | 1 | Synchronous active-high reset, sampled on rising edges |
| sel_i | input | 3 | Divide-ratio code (see R1) |
| clk_o | output | NUM_OUT (2) | Divided clock, one identical copy per channel |
| tick_o | output | 1 | High for each input cycle that contains an output rising edge |

## Verification
Suppose the cycle counter, the held code or either edge register goes wrong. The next output period then shows a wrong high or low run length, and the bench measures each run in input half-periods, so the error is seen within one output period. It is seen within two periods for the 1.5 ratio. A wrong strobe shows up within one input cycle, because every cycle is compared with the output edges that were seen. If a code is taken up early, a period appears that matches neither the old ratio nor the new one, right at the switch.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  localparam int SEL_W = 3;   // width of the ratio code
  localparam int CNT_W = 4;   // holds the longest pattern, 12 input cycles

  typedef enum logic [SEL_W-1:0] {
    DIV_1   = 3'd0,
    DIV_1P5 = 3'd1,
    DIV_2   = 3'd2,
    DIV_3   = 3'd3,
    DIV_4   = 3'd4,
    DIV_6   = 3'd5,
    DIV_8   = 3'd6,
    DIV_12  = 3'd7
  } div_code_e;

  // index of the last input cycle in one repeating output pattern
  function automatic logic [CNT_W-1:0] last_cycle(div_code_e c);
    case (c)
      DIV_1:   return CNT_W'(0);
      DIV_1P5: return CNT_W'(2);   // two output periods span three cycles
      DIV_2:   return CNT_W'(1);
      DIV_3:   return CNT_W'(2);
      DIV_4:   return CNT_W'(3);
      DIV_6:   return CNT_W'(5);
      DIV_8:   return CNT_W'(7);
      default: return CNT_W'(11);
    endcase
  endfunction

  // output level wanted during half-period h of the pattern
  function automatic logic half_high(div_code_e c, logic [CNT_W:0] h);
    logic [CNT_W:0] span;
    span = {1'b0, last_cycle(c)} + 1'b1;
    if (c == DIV_1P5) return (h % (CNT_W+1)'(3)) != (CNT_W+1)'(2);
    return h < span;
  endfunction

endpackage

// File: rtl/fdiv_seq.sv
module fdiv_seq
  import frac_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  output div_code_e        act_o,
  output logic             wrap_o,
  output logic             lvl_even_o,
  output logic             lvl_odd_o,
  output logic             tick_o
);

  div_code_e        act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, lim_q;
  logic             odd_q, tick_q, wrap;

  assign wrap = (cnt_q == lim_q);

  always_comb begin
    act_n = wrap ? div_code_e'(sel_i) : act_q;
    cnt_n = wrap ? '0 : cnt_q + 1'b1;
  end

  // level for the half-period that begins at this rising edge
  assign lvl_even_o = half_high(act_n, {cnt_n, 1'b0});

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q  <= DIV_1;
      cnt_q  <= '0;
      lim_q  <= '0;
      odd_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      lim_q  <= last_cycle(act_n);
      odd_q  <= half_high(act_n, {cnt_n, 1'b1});
      tick_q <= (cnt_n == '0) || (act_n == DIV_1P5 && cnt_n == CNT_W'(1));
    end
  end

  assign act_o     = act_q;
  assign wrap_o    = wrap;
  assign lvl_odd_o = odd_q;
  assign tick_o    = tick_q;

endmodule

// File: rtl/fdiv_edge_pair.sv
module fdiv_edge_pair (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_even_i,
  input  logic lvl_odd_i,
  output logic clk_o
);

  logic rise_q, fall_q;

  // each register flips so that the XOR shows the wanted level
  always_ff @(posedge clk_i) begin
    if (rst_i) rise_q <= 1'b0;
    else       rise_q <= lvl_even_i ^ fall_q;
  end

  always_ff @(negedge clk_i) begin
    fall_q <= lvl_odd_i ^ rise_q;
  end

  assign clk_o = rise_q ^ fall_q;

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic               tick_o
);

  div_code_e act_sel;
  logic      at_wrap, lvl_even, lvl_odd;

  fdiv_seq u_seq (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sel_i      (sel_i),
    .act_o      (act_sel),
    .wrap_o     (at_wrap),
    .lvl_even_o (lvl_even),
    .lvl_odd_o  (lvl_odd),
    .tick_o     (tick_o)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    fdiv_edge_pair u_pair (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .lvl_even_i (lvl_even),
      .lvl_odd_i  (lvl_odd),
      .clk_o      (clk_o[g])
    );
  end

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
  import frac_div_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               tick_o,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [SEL_W-1:0]   act_sel,
  input logic               at_wrap
);

  // R3
  chan_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    clk_o == {NUM_OUT{clk_o[0]}});

  // R4
  code_at_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(act_sel)) |-> $past(at_wrap));

  // R5
  reset_low_chk: assert property (@(posedge clk_i)
    rst_i |=> (clk_o == '0 && !tick_o));

  // R6
  restart_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && $past(rst_i)) |=> tick_o);

endmodule

bind frac_clk_div frac_clk_div_chk #(.NUM_OUT(NUM_OUT)) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .tick_o  (tick_o),
  .clk_o   (clk_o),
  .act_sel (act_sel),
  .at_wrap (at_wrap)
);

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } per_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'd0;
  logic [1:0] ck_o;
  logic       tick;

  int   checks = 0;
  int   errors = 0;
  bit   armed  = 0;
  per_t sb_q[$];

  always #5 clk = ~clk;

  frac_clk_div #(.NUM_OUT(2)) dut_i (
    .clk_i  (clk),
    .rst_i  (rst),
    .sel_i  (sel),
    .clk_o  (ck_o),
    .tick_o (tick)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // period in input half-periods for each code (R1)
  function automatic int halves(int code);
    case (code)
      0: return 2;  1: return 3;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16; default: return 24;
    endcase
  endfunction

  task automatic push_code(int code, int n, string tag);
    for (int i = 0; i < n; i++) begin
      per_t p;
      p.hi  = (halves(code) + 1) / 2;
      p.lo  = halves(code) / 2;
      p.tag = tag;
      sb_q.push_back(p);
    end
  endtask

  // monitor: measure run lengths per half-period and score periods
  logic prev_s = 1'b0, tick_prev = 1'b0, rose_prev = 1'b0, started = 1'b0;
  int   run = 0, hi_len = 0, lo_len = 0;
  always begin
    logic s, pos;
    @(posedge clk or negedge clk);
    pos = clk;
    #2;
    s = ck_o[0];
    if (armed) chk("R3 channel copy", ck_o[1], ck_o[0]);
    if (pos) begin
      if (armed) chk("R7 tick vs rising edge", tick_prev, rose_prev);
      tick_prev = tick;
      rose_prev = 1'b0;
    end
    if (s == prev_s) run++;
    else begin
      if (!s) hi_len = run;
      else begin
        lo_len    = run;
        rose_prev = 1'b1;
        if (armed && started && sb_q.size() != 0) begin
          per_t e;
          e = sb_q.pop_front();
          chk({e.tag, " high halves"}, hi_len, e.hi);
          chk({e.tag, " low halves"}, lo_len, e.lo);
        end
        started = armed;
      end
      run = 1;
    end
    prev_s = s;
  end

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    armed = 0;
  endtask

  // R1 R2: settled ratio, four periods
  task automatic run_code(int code);
    @(negedge clk) sel = 3'(code);
    repeat (30) @(negedge clk);
    push_code(code, 4, "R1 R2");
    armed = 1;
    drain();
  endtask

  // R4: switch right after an output period has begun
  task automatic switch_code(int from, int to);
    @(negedge clk) sel = 3'(from);
    repeat (30) @(negedge clk);
    do @(negedge clk); while (!tick);
    push_code(from, 1, "R4 old");
    push_code(to, 3, "R4 new");
    armed = 1;
    do @(negedge clk); while (!tick);
    sel = 3'(to);
    drain();
  endtask

  // R5 R6: reset during operation, restart with code 011
  task automatic reset_mid();
    @(negedge clk) begin rst = 1'b1; sel = 3'd3; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2;
      chk("R5 clk_o in reset", ck_o, 0);
      chk("R5 tick in reset", tick, 0);
    end
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #2;
    chk("R6 clk_o rises at restart", ck_o, 3);
    chk("R6 tick at restart", tick, 1);
    @(negedge clk); #2; chk("R6 half 1 high", ck_o[0], 1);
    @(posedge clk); #2; chk("R6 half 2 high", ck_o[0], 1);
    @(negedge clk); #2; chk("R6 half 3 low", ck_o[0], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    chk("R5 clk_o at reset", ck_o, 0);
    chk("R5 tick at reset", tick, 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #2;
    chk("R6 first rise after reset", ck_o, 3);
    chk("R6 tick after reset", tick, 1);
    for (int c = 0; c < 8; c++) run_code(c);
    switch_code(6, 3);
    switch_code(7, 1);
    switch_code(2, 0);
    switch_code(0, 7);
    switch_code(4, 5);
    reset_mid();
    run_code(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: %0d periods still pending, expected 0", sb_q.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule